// File: doc/BRIEF.md
# System Tick Countdown Timer

A periodic down-counter for a processor's system control space. Software programs a reload value and a control word over a simple word-wide register bus. The counter then decrements from the reload value towards zero. Each step is taken either on every core clock or on each cycle of an external reference tick enable. When the count passes from one to zero the block raises a sticky count flag and, if enabled, sends a one-cycle interrupt request to the exception controller. On the next step the count reloads, so one period is reload+1 steps.

A zero reload value makes the timer stop itself: the enable bit drops at the next expiry, or at the next step if the count is already at zero. This gives a one-shot mode without a separate control. Reading the control word clears the count flag. Writing the current-value register restarts the count and also clears the flag.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset the control, reload and current-value registers read 0, the calibration register reads 10000 and `irq` is low.
- R2: The registers sit at byte offsets 0x10 (control), 0x14 (reload), 0x18 (current value) and 0x1C (calibration). A read of any other offset returns 0.
- R3: Control bit 0 enables counting, bit 1 enables the interrupt and bit 2 selects the source (1 = core clock, 0 = reference tick). Bit 16 is the count flag. Only bits 2:0 are writable, and a control write never changes the flag.
- R4: With bit 2 set the period between expiries is reload+1 clock cycles. With bit 2 clear the counter steps only on cycles where `ref_tick` is high.
- R5: `irq` is a one-cycle pulse, issued in the cycle after the counter steps from 1 to 0 and only when control bit 1 is set. It stays low while the timer is disabled.
- R6: Each expiry sets the count flag. A control read returns the flag and then clears it. If an expiry falls in the same cycle as that read, the flag stays set.
- R7: If the reload value is 0 at an expiry, the enable bit clears and counting stops. A counter already at zero with reload 0 also clears enable at its next step, without setting the flag.
- R8: Any write to the current-value register reloads the count from the reload value and clears the count flag.
- R9: The current-value register reads 0 while the timer is disabled. Turning the enable bit on loads the count from the reload value.
- R10: The calibration register is read-only. The reload register holds 24 bits, and bits 31:24 read as zero.
- R11: A control write that changes the source bit reloads the count from the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Reference tick enable, one cycle per step |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq | output | 1 | One-cycle tick interrupt request |

## Verification
The hardest case to reach from the ports is a control read that lands in the very cycle of an expiry. In that cycle the flag's clear and set collide. The bench enables the core-clock source with a small reload and counts bus cycles from the enabling write, so that the read strobe spans exactly the expiry edge. It then checks that the read returns the old flag, and that the next read still sees it set. A second hard case is making the one-shot stop happen mid-count: the bench lowers the reload to zero while a count is already running.

// File: rtl/sys_tick_timer.sv
module sys_tick_timer #(
  parameter int CNT_W     = 24,
  parameter int ADDR_W    = 12,
  parameter int CAL_VALUE = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(12'h010);
  localparam logic [ADDR_W-1:0] OFS_RLD  = ADDR_W'(12'h014);
  localparam logic [ADDR_W-1:0] OFS_CUR  = ADDR_W'(12'h018);
  localparam logic [ADDR_W-1:0] OFS_CAL  = ADDR_W'(12'h01C);
  localparam logic [CNT_W-1:0]  ONE      = CNT_W'(1);

  logic             en, tint, csrc, flag, irq_q;
  logic [CNT_W-1:0] cur, rld;

  wire wr_ctrl = bus_sel &  bus_wr & (bus_addr == OFS_CTRL);
  wire rd_ctrl = bus_sel & ~bus_wr & (bus_addr == OFS_CTRL);
  wire wr_rld  = bus_sel &  bus_wr & (bus_addr == OFS_RLD);
  wire wr_cur  = bus_sel &  bus_wr & (bus_addr == OFS_CUR);

  wire step     = en & (csrc | ref_tick);
  wire hit      = step & (cur == ONE) & ~wr_ctrl & ~wr_cur;
  wire wrap     = step & (cur == '0) & ~wr_ctrl & ~wr_cur;
  wire restart  = wr_cur | (wr_ctrl & ((bus_wdata[0] & ~en) | (bus_wdata[2] != csrc)));
  wire zero_rld = (rld == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en    <= 1'b0;
      tint  <= 1'b0;
      csrc  <= 1'b0;
      flag  <= 1'b0;
      cur   <= '0;
      rld   <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= hit & tint;

      if (wr_rld) rld <= bus_wdata[CNT_W-1:0];

      if (wr_ctrl) begin
        en   <= bus_wdata[0];
        tint <= bus_wdata[1];
        csrc <= bus_wdata[2];
      end else if ((hit | wrap) && zero_rld) begin
        en <= 1'b0;
      end

      if (restart)     cur <= rld;
      else if (wrap)   cur <= rld;
      else if (hit)    cur <= '0;
      else if (step && !wr_ctrl) cur <= cur - ONE;

      if (hit)                  flag <= 1'b1;
      else if (wr_cur | rd_ctrl) flag <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (bus_addr)
        OFS_CTRL: bus_rdata = {15'd0, flag, 13'd0, csrc, tint, en};
        OFS_RLD:  bus_rdata = 32'(rld);
        OFS_CUR:  bus_rdata = en ? 32'(cur) : 32'd0;
        OFS_CAL:  bus_rdata = 32'(CAL_VALUE);
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/sys_tick_timer_chk.sv
module sys_tick_timer_chk #(
  parameter int CNT_W     = 24,
  parameter int ADDR_W    = 12,
  parameter int CAL_VALUE = 10000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              irq,
  input logic              en,
  input logic              flag,
  input logic [CNT_W-1:0]  cur,
  input logic [CNT_W-1:0]  rld
);
  localparam logic [ADDR_W-1:0] C_RLD = ADDR_W'(12'h014);
  localparam logic [ADDR_W-1:0] C_CUR = ADDR_W'(12'h018);
  localparam logic [ADDR_W-1:0] C_CAL = ADDR_W'(12'h01C);

  wire cur_wr = bus_sel & bus_wr & (bus_addr == C_CUR);

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R5
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !irq); // R5
  AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag); // R6
  AST_CUR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cur_wr |=> (cur == $past(rld))); // R8
  AST_CUR_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    cur_wr |=> !flag); // R8
  AST_CAL_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == C_CAL) |-> (bus_rdata == 32'(CAL_VALUE))); // R10
  AST_RLD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == C_RLD) |-> (bus_rdata >> CNT_W) == 32'd0); // R10
endmodule

bind sys_tick_timer sys_tick_timer_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .CAL_VALUE(CAL_VALUE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq(irq),
  .en(en), .flag(flag), .cur(cur), .rld(rld)
);

// File: tb/sys_tick_timer_bench.sv
module sys_tick_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0, errors = 0;
  int cyc = 0, irq_n = 0, t_last = 0, t_prev = 0;
  logic tick_on = 1'b0;
  int phase = 0;
  bit done = 1'b0;

  sys_tick_timer u_sys_tick_timer (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    phase    = (phase == 2) ? 0 : phase + 1;
    ref_tick = tick_on && (phase == 0);
    if (irq) begin
      irq_n++;
      t_prev = t_last;
      t_last = cyc;
    end
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000 && !done) begin
    done = 1'b1;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  task automatic chk(string req, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic quiesce();
    logic [31:0] d;
    wr(12'h010, 32'h0);
    rd(12'h010, d);
  endtask

  task automatic period_run(int r, bit core);
    int base;
    quiesce();
    tick_on = !core;
    wr(12'h014, r);
    wr(12'h010, core ? 32'h7 : 32'h3);
    base = irq_n;
    while (irq_n < base + 3) @(negedge clk);
    chk(core ? "R4 core period" : "R4 ref period", t_last - t_prev,
        core ? (r + 1) : 3 * (r + 1));
    tick_on = 1'b0;
  endtask

  initial begin
    logic [31:0] d;
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    chk("R1 irq", irq, 0);
    rd(12'h010, d); chk("R1 ctrl", d, 0);
    rd(12'h014, d); chk("R1 reload", d, 0);
    rd(12'h018, d); chk("R1 current", d, 0);
    rd(12'h01C, d); chk("R1 calib", d, 10000);
    rd(12'h020, d); chk("R2 unmapped", d, 0);

    wr(12'h014, 32'hFFFF_FFFF);
    rd(12'h014, d); chk("R10 reload width", d, 32'h00FF_FFFF);
    wr(12'h01C, 32'h0);
    rd(12'h01C, d); chk("R10 calib ro", d, 10000);

    for (int r = 1; r <= 6; r++) period_run(r, 1'b1);
    for (int r = 1; r <= 4; r++) period_run(r, 1'b0);

    quiesce();
    wr(12'h010, 32'h0001_0000);
    rd(12'h010, d); chk("R3 flag not writable", d, 0);

    wr(12'h014, 3);
    n0 = irq_n;
    wr(12'h010, 32'h5);
    idle(12);
    wr(12'h010, 32'h0001_0000);
    rd(12'h010, d); chk("R3 ctrl write keeps flag", d, 32'h0001_0000);
    rd(12'h010, d); chk("R6 read clears flag", d, 0);
    rd(12'h018, d); chk("R9 disabled reads zero", d, 0);
    chk("R5 no irq when masked", irq_n - n0, 0);

    quiesce();
    wr(12'h014, 3);
    wr(12'h010, 32'h5);
    idle(1);
    rd(12'h010, d); chk("R6 read at expiry old", d, 32'h5);
    rd(12'h010, d); chk("R6 set wins over clear", d, 32'h0001_0005);
    rd(12'h010, d); chk("R6 cleared after read", d, 32'h5);

    quiesce();
    tick_on = 1'b0;
    wr(12'h014, 4);
    wr(12'h010, 32'h1);
    rd(12'h018, d); chk("R9 enable loads reload", d, 4);
    tick_on = 1'b1;
    idle(20);
    tick_on = 1'b0;
    idle(4);
    wr(12'h018, 32'h0);
    rd(12'h010, d); chk("R8 write clears flag", d, 32'h1);
    rd(12'h018, d); chk("R8 write restarts", d, 4);

    quiesce();
    wr(12'h014, 9);
    wr(12'h010, 32'h5);
    idle(5);
    wr(12'h010, 32'h1);
    rd(12'h018, d); chk("R11 source change reload", d, 9);

    quiesce();
    wr(12'h014, 5);
    n0 = irq_n;
    wr(12'h010, 32'h7);
    wr(12'h014, 0);
    idle(20);
    rd(12'h010, d); chk("R7 one-shot stops", d, 32'h0001_0006);
    chk("R7 one-shot single irq", irq_n - n0, 1);
    rd(12'h018, d); chk("R7 stopped current", d, 0);

    quiesce();
    wr(12'h014, 0);
    n0 = irq_n;
    wr(12'h010, 32'h7);
    idle(5);
    rd(12'h010, d); chk("R7 zero start stops", d, 32'h6);
    chk("R7 zero start no irq", irq_n - n0, 0);

    done = 1'b1;
    report();
  end
endmodule